// File: doc/BRIEF.md
# Interrupt redirection table controller

This block turns a bank of external interrupt pins into interrupt messages. Every pin owns one redirection entry. The entry gives the vector, the delivery mode and the destination, and it sets the pin's polarity, whether the pin is edge or level triggered, and whether it is masked. Every pin passes through a two-flop synchronizer. After that, the entry's polarity bit can invert it, so that "active" always means logic one. Messages leave through a single registered valid/ready output stage.

Software reaches the entries through an indirect window. A select port holds a register index, and a data port reads or writes the register that the index names. A version register reports the block revision and the highest entry index. A write to a third port is a broadcast end-of-interrupt (EOI) carrying a vector. It re-arms every level-triggered entry that is busy and holds that vector.

Back-pressure rules for the output: once `msg_valid` rises, it stays high and the payload stays unchanged until a cycle in which `msg_ready` is high. That cycle is the accept. The stage is loaded only while it is empty, so at least one idle cycle follows every accept.

Top module: `irq_redir_ctrl`

## Requirements
- R1: After reset, every entry is masked, `msg_valid` is low, each low word reads 0x0001_0000 and each high word reads 0.
- R2: Window index 0x01 is a read-only version word. Bits 7:0 hold the revision parameter, bits 23:16 hold the number of pins minus one, and bits 15:8 and 31:24 read zero.
- R3: Port address 0 writes and reads the 8-bit select value. Port address 1 accesses the register that the select value names. Window index 0x00 reads back the select value. Index 0x10+2n is the low word of entry n and index 0x11+2n is its high word. Unknown indexes read zero and ignore writes.
- R4: In the low word, bits 7:0 are the vector, bits 10:8 the delivery mode, bit 13 the polarity (1 = active low), bit 15 the trigger mode (1 = level) and bit 16 the mask. Every other bit reads zero. The high word holds the 16-bit destination in bits 31:16, with the ID in 31:24 and the extended ID in 23:16. Delivery modes are 000 fixed, 001 lowest priority, 010 PMI and 101 INIT. The message carries the vector, destination and mode unchanged.
- R5: A pin whose polarity bit is 1 is treated as active when it is low.
- R6: Each active edge on an unmasked edge-triggered entry produces exactly one message. An edge that arrives while the entry is masked is discarded, and unmasking the entry later sends nothing for it.
- R7: A level-triggered entry that is active and unmasked sends one message and becomes busy when that message is accepted. It sends nothing more until an EOI write (port address 2, vector in bits 7:0) matches its vector. That EOI clears the busy state of every entry holding the vector, so a line that is still active is delivered again.
- R8: When several entries request at once, the lowest-numbered entry is loaded first.
- R9: While `msg_valid` is high and `msg_ready` is low, the valid signal and the payload hold steady. After each accept the stage is empty for at least one cycle.
- R10: An edge entry's pending flag clears when its message is loaded into the output stage. An edge that arrives after that point, including while the message waits for `msg_ready`, is kept and produces a further message.
- R11: An EOI whose vector matches no busy entry changes no entry and causes no message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | NUM_PINS | Asynchronous interrupt pins |
| bus_addr | input | 2 | Port address: 0 select, 1 data window, 2 EOI |
| bus_wr | input | 1 | Write strobe for the addressed port |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed port (combinational) |
| msg_valid | output | 1 | Message present in the output stage |
| msg_ready | input | 1 | Receiver takes the message |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 16 | Message destination (ID and extended ID) |
| msg_dmode | output | 3 | Message delivery mode |

## Verification
The risky overlap is a new active edge on an edge entry at the same moment its previous message is being loaded into the output stage, or while that message waits for the receiver. Clearing the pending flag at load and setting it from the new edge then compete in the same cycle. The bench forces this by holding `msg_ready` low, pulsing the same pin a second time and then releasing the receiver. It expects exactly two messages. A behavioural reference model predicts the output stage on every clock, so a lost or duplicated message is reported in the cycle where it diverges. The second overlap is an EOI that re-arms two entries sharing one vector while both lines stay active. The expected outcome there is two fresh messages in index order.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  // delivery-mode encodings
  localparam logic [2:0] DM_FIXED  = 3'b000;
  localparam logic [2:0] DM_LOWPRI = 3'b001;
  localparam logic [2:0] DM_PMI    = 3'b010;
  localparam logic [2:0] DM_INIT   = 3'b101;

  // port addresses
  localparam logic [1:0] PORT_SEL  = 2'd0;
  localparam logic [1:0] PORT_DATA = 2'd1;
  localparam logic [1:0] PORT_EOI  = 2'd2;

  // window indexes
  localparam int IDX_SEL = 0;
  localparam int IDX_VER = 1;
  localparam int IDX_TBL = 16;

  // low/high word field positions
  localparam int LO_DM_POS   = 8;
  localparam int LO_POL_POS  = 13;
  localparam int LO_LVL_POS  = 15;
  localparam int LO_MASK_POS = 16;
  localparam int HI_DEST_POS = 16;

  typedef struct packed {
    logic [7:0]  vector;
    logic [2:0]  dmode;
    logic        pol;
    logic        level;
    logic        mask;
    logic [15:0] dest;
  } redir_entry_t;

  function automatic logic [31:0] pack_low(redir_entry_t e);
    logic [31:0] w;
    w = '0;
    w[7:0]               = e.vector;
    w[LO_DM_POS +: 3]    = e.dmode;
    w[LO_POL_POS]        = e.pol;
    w[LO_LVL_POS]        = e.level;
    w[LO_MASK_POS]       = e.mask;
    return w;
  endfunction

  function automatic logic [31:0] pack_high(redir_entry_t e);
    logic [31:0] w;
    w = '0;
    w[HI_DEST_POS +: 16] = e.dest;
    return w;
  endfunction

endpackage

// File: rtl/irq_pin_cond.sv
module irq_pin_cond #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] pol,
  output logic [NUM_PINS-1:0] act,
  output logic [NUM_PINS-1:0] rise
);

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_pin
      logic s1_q, s2_q, prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s1_q   <= 1'b0;
          s2_q   <= 1'b0;
          prev_q <= 1'b0;
        end else begin
          s1_q   <= pin_in[g];
          s2_q   <= s1_q;
          prev_q <= act[g];
        end
      end

      assign act[g]  = s2_q ^ pol[g];
      assign rise[g] = act[g] && !prev_q;

      // R5: a detected edge lasts a single cycle
      a_r5_rise_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rise[g] |=> !rise[g]);
    end
  endgenerate

endmodule

// File: rtl/irq_entry_regs.sv
module irq_entry_regs
  import irq_redir_pkg::*;
#(
  parameter int          NUM_PINS = 8,
  parameter logic [7:0]  VERSION  = 8'h21
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          bus_addr,
  input  logic                bus_wr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output redir_entry_t        entries [NUM_PINS],
  output logic [NUM_PINS-1:0] eoi_hit
);

  localparam logic [7:0] MAX_IDX = 8'(NUM_PINS - 1);

  logic [7:0]  sel_q;
  logic [31:0] win_word;
  logic        data_wr, eoi_wr;

  assign data_wr = bus_wr && (bus_addr == PORT_DATA);
  assign eoi_wr  = bus_wr && (bus_addr == PORT_EOI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 sel_q <= 8'd0;
    else if (bus_wr && bus_addr == PORT_SEL)    sel_q <= bus_wdata[7:0];
  end

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_ent
      localparam int LO_IDX = IDX_TBL + 2 * g;
      logic wr_lo, wr_hi;
      assign wr_lo = data_wr && (int'(sel_q) == LO_IDX);
      assign wr_hi = data_wr && (int'(sel_q) == LO_IDX + 1);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          entries[g] <= '{vector: 8'd0, dmode: 3'd0, pol: 1'b0,
                          level: 1'b0, mask: 1'b1, dest: 16'd0};
        end else begin
          if (wr_lo) begin
            entries[g].vector <= bus_wdata[7:0];
            entries[g].dmode  <= bus_wdata[LO_DM_POS +: 3];
            entries[g].pol    <= bus_wdata[LO_POL_POS];
            entries[g].level  <= bus_wdata[LO_LVL_POS];
            entries[g].mask   <= bus_wdata[LO_MASK_POS];
          end
          if (wr_hi) entries[g].dest <= bus_wdata[HI_DEST_POS +: 16];
        end
      end

      assign eoi_hit[g] = eoi_wr && (bus_wdata[7:0] == entries[g].vector);

      // R7: an EOI write never alters an entry
      a_r7_eoi_keeps_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == PORT_EOI) |=> (entries[g] == $past(entries[g])));
    end
  endgenerate

  always_comb begin
    win_word = 32'd0;
    if (int'(sel_q) == IDX_SEL)      win_word = {24'd0, sel_q};
    else if (int'(sel_q) == IDX_VER) win_word = {8'd0, MAX_IDX, 8'd0, VERSION};
    for (int i = 0; i < NUM_PINS; i++) begin
      if (int'(sel_q) == IDX_TBL + 2 * i)     win_word = pack_low(entries[i]);
      if (int'(sel_q) == IDX_TBL + 2 * i + 1) win_word = pack_high(entries[i]);
    end
  end

  always_comb begin
    case (bus_addr)
      PORT_SEL:  bus_rdata = {24'd0, sel_q};
      PORT_DATA: bus_rdata = win_word;
      default:   bus_rdata = 32'd0;
    endcase
  end

  // R1: the first cycle out of reset finds every entry masked
  logic [NUM_PINS-1:0] mask_v;
  always_comb for (int i = 0; i < NUM_PINS; i++) mask_v[i] = entries[i].mask;
  a_r1_reset_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (&mask_v));

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  redir_entry_t        entries [NUM_PINS],
  input  logic [NUM_PINS-1:0] act,
  input  logic [NUM_PINS-1:0] rise,
  input  logic [NUM_PINS-1:0] eoi_hit,
  input  logic                msg_ready,
  output logic                msg_valid,
  output logic [7:0]          msg_vector,
  output logic [15:0]         msg_dest,
  output logic [2:0]          msg_dmode
);

  localparam int IW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [NUM_PINS-1:0] pend_q, busy_q, req;
  logic [IW-1:0]       win, sel_q;
  logic                any, load, accept;

  assign accept = msg_valid && msg_ready;
  assign load   = !msg_valid && any;

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_trk
      assign req[g] = !entries[g].mask &&
                      (entries[g].level ? (act[g] && !busy_q[g]) : pend_q[g]);

      // edge entries: pending flag, dropped while masked
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                pend_q[g] <= 1'b0;
        else if (entries[g].mask || entries[g].level) pend_q[g] <= 1'b0;
        else pend_q[g] <= (pend_q[g] && !(load && win == IW'(g))) || rise[g];
      end

      // level entries: busy from accept until a matching EOI
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                            busy_q[g] <= 1'b0;
        else if (accept && sel_q == IW'(g) && entries[g].level) busy_q[g] <= 1'b1;
        else if (eoi_hit[g])                                   busy_q[g] <= 1'b0;
      end
    end
  endgenerate

  // lowest index wins
  always_comb begin
    win = '0;
    any = 1'b0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (req[i]) begin
        win = IW'(i);
        any = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid  <= 1'b0;
      sel_q      <= '0;
      msg_vector <= 8'd0;
      msg_dest   <= 16'd0;
      msg_dmode  <= 3'd0;
    end else if (load) begin
      msg_valid  <= 1'b1;
      sel_q      <= win;
      msg_vector <= entries[win].vector;
      msg_dest   <= entries[win].dest;
      msg_dmode  <= entries[win].dmode;
    end else if (accept) begin
      msg_valid  <= 1'b0;
    end
  end

  // R9: back-pressure keeps valid and payload steady
  a_r9_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> msg_valid);
  a_r9_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> ($stable(msg_vector) && $stable(msg_dest) && $stable(msg_dmode)));
  // R9: an idle cycle follows every accept
  a_r9_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !msg_valid);
  // R6: a masked entry is never loaded
  a_r6_no_masked_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !entries[win].mask);
  // R7: a busy level entry is never loaded
  a_r7_no_busy_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load && entries[win].level) |-> !busy_q[win]);

endmodule

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
  import irq_redir_pkg::*;
#(
  parameter int         NUM_PINS = 8,
  parameter logic [7:0] VERSION  = 8'h21
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_pin,
  input  logic [1:0]          bus_addr,
  input  logic                bus_wr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [7:0]          msg_vector,
  output logic [15:0]         msg_dest,
  output logic [2:0]          msg_dmode
);

  redir_entry_t        entries [NUM_PINS];
  logic [NUM_PINS-1:0] pol_v, act, rise, eoi_hit;

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_pol
      assign pol_v[g] = entries[g].pol;
    end
  endgenerate

  irq_entry_regs #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .entries(entries),
    .eoi_hit(eoi_hit)
  );

  irq_pin_cond #(.NUM_PINS(NUM_PINS)) u_pins (
    .clk(clk), .rst_n(rst_n), .pin_in(irq_pin), .pol(pol_v),
    .act(act), .rise(rise)
  );

  irq_dispatch #(.NUM_PINS(NUM_PINS)) u_disp (
    .clk(clk), .rst_n(rst_n), .entries(entries), .act(act), .rise(rise),
    .eoi_hit(eoi_hit), .msg_ready(msg_ready), .msg_valid(msg_valid),
    .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_dmode(msg_dmode)
  );

endmodule

// File: tb/irq_redir_ctrl_test.sv
module irq_redir_ctrl_test;
  localparam int         NP  = 8;
  localparam logic [7:0] VER = 8'h21;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NP-1:0] pins;
  logic [1:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  wire  [31:0] bus_rdata;
  logic        msg_ready;
  wire         msg_valid;
  wire  [7:0]  msg_vector;
  wire  [15:0] msg_dest;
  wire  [2:0]  msg_dmode;

  always #10 clk = ~clk;

  irq_redir_ctrl #(.NUM_PINS(NP), .VERSION(VER)) uut (
    .clk(clk), .rst_n(rst_n), .irq_pin(pins), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_dest(msg_dest), .msg_dmode(msg_dmode)
  );

  int checks = 0, fails = 0, cyc = 0, nmsg = 0;
  logic [7:0]  last_vec;
  logic [15:0] last_dest;
  logic [2:0]  last_dm;
  logic [2:0]  dm_log [$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0]  m_vec  [NP];
  logic [2:0]  m_dm   [NP];
  logic [15:0] m_dest [NP];
  bit m_pol [NP], m_lvl [NP], m_mask [NP];
  bit m_s1 [NP], m_s2 [NP], m_prev [NP], m_pend [NP], m_busy [NP];
  bit m_ov;
  int m_sel;
  logic [7:0]  m_ovec;
  logic [15:0] m_odest;
  logic [2:0]  m_odm;
  logic [7:0]  m_selreg;

  always @(posedge clk) begin
    bit a [NP];
    bit r [NP];
    bit q [NP];
    int win;
    bit acc, eoi;
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) begin
        m_vec[i] = 0; m_dm[i] = 0; m_dest[i] = 0; m_pol[i] = 0; m_lvl[i] = 0;
        m_mask[i] = 1; m_s1[i] = 0; m_s2[i] = 0; m_prev[i] = 0;
        m_pend[i] = 0; m_busy[i] = 0;
      end
      m_ov = 0; m_sel = 0; m_ovec = 0; m_odest = 0; m_odm = 0; m_selreg = 0;
    end else begin
      acc = m_ov && msg_ready;
      eoi = bus_wr && bus_addr == 2'd2;
      win = -1;
      for (int i = 0; i < NP; i++) begin
        a[i] = m_s2[i] ^ m_pol[i];
        r[i] = a[i] && !m_prev[i];
        q[i] = !m_mask[i] && (m_lvl[i] ? (a[i] && !m_busy[i]) : m_pend[i]);
      end
      if (!m_ov) for (int i = NP - 1; i >= 0; i--) if (q[i]) win = i;
      for (int i = 0; i < NP; i++) begin
        if (m_mask[i] || m_lvl[i]) m_pend[i] = 0;
        else m_pend[i] = (m_pend[i] && win != i) || r[i];
      end
      if (acc && m_lvl[m_sel]) m_busy[m_sel] = 1;
      for (int i = 0; i < NP; i++)
        if (eoi && bus_wdata[7:0] == m_vec[i] && !(acc && i == m_sel && m_lvl[i]))
          m_busy[i] = 0;
      if (win >= 0) begin
        m_ov = 1; m_sel = win; m_ovec = m_vec[win]; m_odest = m_dest[win]; m_odm = m_dm[win];
      end else if (acc) m_ov = 0;
      for (int i = 0; i < NP; i++) begin
        m_prev[i] = a[i]; m_s2[i] = m_s1[i]; m_s1[i] = pins[i];
      end
      if (bus_wr && bus_addr == 2'd0) m_selreg = bus_wdata[7:0];
      if (bus_wr && bus_addr == 2'd1)
        for (int i = 0; i < NP; i++) begin
          if (int'(m_selreg) == 16 + 2 * i) begin
            m_vec[i] = bus_wdata[7:0]; m_dm[i] = bus_wdata[10:8];
            m_pol[i] = bus_wdata[13]; m_lvl[i] = bus_wdata[15]; m_mask[i] = bus_wdata[16];
          end
          if (int'(m_selreg) == 17 + 2 * i) m_dest[i] = bus_wdata[31:16];
        end
    end
  end

  // message monitor and watchdog
  always @(posedge clk) begin
    cyc++;
    if (rst_n && msg_valid && msg_ready) begin
      nmsg++; last_vec = msg_vector; last_dest = msg_dest; last_dm = msg_dmode;
      dm_log.push_back(msg_dmode);
    end
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<100000 cycles", cyc);
      finish_run();
    end
  end

  // cycle compare against the model (R9 output stage)
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 model valid", {31'd0, msg_valid}, {31'd0, m_ov});
      if (m_ov) chk("R4 model payload", {5'd0, msg_dmode, msg_dest, msg_vector},
                    {5'd0, m_odm, m_odest, m_ovec});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [31:0] d);
    bus_write(2'd0, {24'd0, idx});
    bus_write(2'd1, d);
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [31:0] d);
    bus_write(2'd0, {24'd0, idx});
    bus_addr = 2'd1;
    #1 d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int i);
    @(negedge clk); pins[i] = ~pins[i];
    wait_cyc(3);    pins[i] = ~pins[i];
  endtask

  function automatic logic [31:0] lw(input logic [7:0] v, input logic [2:0] dm,
                                     input bit pol, input bit lvl, input bit msk);
    return {15'd0, msk, lvl, 1'b0, pol, 2'b00, dm, v};
  endfunction

  initial begin
    logic [31:0] rd;
    int base;
    pins = 8'h02; bus_addr = 2'd0; bus_wr = 1'b0; bus_wdata = 32'd0; msg_ready = 1'b1;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    chk("R1 valid low", {31'd0, msg_valid}, 32'd0);
    reg_read(8'h10, rd); chk("R1 low word entry0", rd, 32'h0001_0000);
    reg_read(8'h1F, rd); chk("R1 high word entry7", rd, 32'h0);
    // R2 version
    reg_read(8'h01, rd); chk("R2 version", rd, {8'd0, 8'(NP - 1), 8'd0, VER});
    // R3 select readback, index 0 and unknown index
    reg_read(8'h00, rd); chk("R3 index0 reads select", rd, 32'h0);
    bus_write(2'd0, 32'h0000_0011); bus_addr = 2'd0;
    #1 chk("R3 select port", bus_rdata, 32'h11);
    reg_write(8'h7F, 32'hFFFF_FFFF);
    reg_read(8'h7F, rd); chk("R3 unknown index", rd, 32'h0);

    // R4 field positions, reserved bits
    reg_write(8'h18, 32'hFFFF_FFFF);
    reg_read(8'h18, rd); chk("R4 low reserved bits", rd, 32'h0001_A7FF);
    reg_write(8'h18, 32'h0001_0000);
    reg_write(8'h11, 32'h1234_0000);
    reg_write(8'h10, lw(8'h31, 3'b000, 0, 0, 0));
    reg_read(8'h11, rd); chk("R4 high word", rd, 32'h1234_0000);

    // R6 edge delivery
    base = nmsg;
    pulse(0); wait_cyc(12);
    chk("R6 one message per edge", nmsg - base, 1);
    chk("R4 vector", {24'd0, last_vec}, 32'h31);
    chk("R4 dest", {16'd0, last_dest}, 32'h1234);
    chk("R4 mode fixed", {29'd0, last_dm}, 32'd0);

    // R6 edge while masked dropped
    reg_write(8'h10, lw(8'h31, 3'b000, 0, 0, 1));
    base = nmsg;
    pulse(0); wait_cyc(8);
    reg_write(8'h10, lw(8'h31, 3'b000, 0, 0, 0));
    wait_cyc(12);
    chk("R6 masked edge dropped", nmsg - base, 0);

    // R5 active-low edge, INIT mode
    reg_write(8'h13, 32'h00AB_0000);
    reg_write(8'h12, lw(8'h42, 3'b101, 1, 0, 0));
    reg_read(8'h12, rd); chk("R4 low readback", rd, 32'h0000_2542);
    base = nmsg;
    pulse(1); wait_cyc(12);
    chk("R5 active-low count", nmsg - base, 1);
    chk("R5 vector", {24'd0, last_vec}, 32'h42);
    chk("R4 mode INIT", {29'd0, last_dm}, 32'd5);

    // R7 / R8 level entries sharing a vector
    reg_write(8'h14, lw(8'h50, 3'b001, 0, 1, 0));
    reg_write(8'h16, lw(8'h50, 3'b010, 0, 1, 0));
    dm_log.delete();
    base = nmsg;
    @(negedge clk); pins[2] = 1'b1; pins[3] = 1'b1;
    wait_cyc(20);
    chk("R7 one message each", nmsg - base, 2);
    chk("R8 lowest first", {29'd0, dm_log[0]}, 32'd1);
    chk("R8 next entry", {29'd0, dm_log[1]}, 32'd2);
    base = nmsg;
    bus_write(2'd2, 32'h51); wait_cyc(20);
    chk("R11 foreign EOI", nmsg - base, 0);
    bus_write(2'd2, 32'h50); wait_cyc(20);
    chk("R7 EOI redelivers both", nmsg - base, 2);
    @(negedge clk); pins[2] = 1'b0; pins[3] = 1'b0;
    wait_cyc(6);
    base = nmsg;
    bus_write(2'd2, 32'h50); wait_cyc(20);
    chk("R7 released line quiet", nmsg - base, 0);
    reg_write(8'h14, 32'h0001_0000);
    reg_write(8'h16, 32'h0001_0000);

    // R9 / R10 back-pressure and edge during handshake
    msg_ready = 1'b0;
    base = nmsg;
    pulse(0); wait_cyc(10);
    chk("R9 valid held", {31'd0, msg_valid}, 32'd1);
    chk("R9 payload held", {24'd0, msg_vector}, 32'h31);
    pulse(0); wait_cyc(10);
    chk("R9 nothing accepted", nmsg - base, 0);
    msg_ready = 1'b1;
    wait_cyc(12);
    chk("R10 edge during handshake kept", nmsg - base, 2);

    finish_run();
  end

endmodule